// File: doc/BRIEF.md
# Extended Port Mode Register Bank with Test FIFO

This block is the extended register bank of a parallel port. It sits behind a second address window of four byte-wide offsets and holds the mode selector that the rest of the port follows, a general configuration byte, a plain data byte and a small byte FIFO. Software selects one of eight operating modes through the extended control register. The block only stores that choice and presents it on `mode_o`. Transfers on the pins and any DMA are handled elsewhere.

The FIFO can be reached from the host only in the FIFO-test mode. In that mode, writes to offset 0 push bytes and reads from offset 0 pop them, and the fill state appears in the two low bits of the extended control register. Any write that changes the mode field empties the FIFO. In every other mode, offset 0 is an ordinary byte register. The exception is the configuration mode, where reading offset 0 returns a constant capability byte that reports the FIFO word width.

A host access lasts one cycle. A write takes effect at the clock edge where `wr_en` is sampled. A read is sampled at an edge, and its result appears on `rdata` after that edge and stays there until the next read.

Top module: `ecx_bank`

## Requirements
- R1: After reset, `mode_o` is 000. The extended control register (offset 2) reads 0x01. Offsets 1 and 0 read 0x00, and `rdata` is 0x00.
- R2: A write to offset 2 stores bits 7:5 as the mode and bits 4:2 as written. Bits 1:0 ignore the written value and always read as FIFO status: 01 empty, 10 full, 00 partly filled.
- R3: `mode_o` equals the stored mode field from the edge after the write to offset 2. The codes are 000 compatible, 001 byte, 010 parallel FIFO, 011 extended FIFO, 100 address/data strobe, 101 reserved, 110 FIFO test and 111 configuration.
- R4: In mode 110, a write to offset 0 pushes the byte into the FIFO. The status then reads 00 if space remains and 10 once the FIFO holds `FIFO_DEPTH` bytes. The value 11 never appears.
- R5: In mode 110, a read from offset 0 pops the oldest byte. Pointers wrap circularly at `FIFO_DEPTH`. The status reads 01 when the FIFO has drained and 00 otherwise.
- R6: A push while full is dropped: stored bytes, pointers and status do not change.
- R7: A pop while empty returns the byte most recently popped (0x00 if none) and leaves the status at 01.
- R8: A write to offset 2 whose mode field differs from the current mode empties the FIFO. A write with the same mode field keeps the FIFO contents.
- R9: Outside mode 110, writes to offset 0 go to the plain data register and never touch the FIFO. Reads from offset 0 return that register in every mode except 110 and 111.
- R10: Offset 1 is a read/write configuration byte.
- R11: In mode 111, a read from offset 0 returns the capability byte. Bits 6:4 hold the width code (001 8-bit, 000 16-bit, 010 32-bit) and all other bits are 0.
- R12: Offset 3 reads 0xFF, and writes to it change nothing.
- R13: `rdata` changes only after an edge where `rd_en` is high and `wr_en` is low. When both are high, the write is performed and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per access |
| rd_en | input | 1 | Host read strobe, one cycle per access |
| addr | input | 2 | Register offset in the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| mode_o | output | 3 | Current operating mode for the rest of the port |

## Verification
The bench builds the block with the default two-entry FIFO and 8-bit width. With these values, the full state is reached after two pushes, and the third push lands in a wrapped write slot, which exercises circular reuse. The capability byte is expected to read 0x10. Expected read values pass through a scoreboard queue that mirrors the fill state in the bench. This covers dropped pushes, empty pops that return the held byte, and the difference between rewriting the same mode and changing it.

// File: rtl/ecx_pkg.sv
package ecx_pkg;

  typedef enum logic [2:0] {
    MD_COMPAT = 3'd0,
    MD_BYTE   = 3'd1,
    MD_PFIFO  = 3'd2,
    MD_XFIFO  = 3'd3,
    MD_STROBE = 3'd4,
    MD_RSVD   = 3'd5,
    MD_FTEST  = 3'd6,
    MD_CONFIG = 3'd7
  } ecx_mode_e;

  localparam logic [1:0] ADR_DATA = 2'd0;
  localparam logic [1:0] ADR_CFGB = 2'd1;
  localparam logic [1:0] ADR_CTRL = 2'd2;
  localparam logic [1:0] ADR_NONE = 2'd3;

  localparam logic [1:0] ST_PART  = 2'b00;
  localparam logic [1:0] ST_EMPTY = 2'b01;
  localparam logic [1:0] ST_FULL  = 2'b10;

  // fill status from a level and the capacity
  function automatic logic [1:0] status_of(input int unsigned level, input int unsigned cap);
    if (level == 0)        return ST_EMPTY;
    else if (level >= cap) return ST_FULL;
    else                   return ST_PART;
  endfunction

  // width code reported in the capability byte
  function automatic logic [2:0] width_code(input int unsigned bits);
    case (bits)
      16:      return 3'b000;
      32:      return 3'b010;
      default: return 3'b001;
    endcase
  endfunction

endpackage

// File: rtl/ecx_fifo.sv
module ecx_fifo #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned DW    = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             clear,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [DW-1:0]    slot_v [DEPTH];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              q <= '0;
      else if (push && wr_ptr == PTR_W'(i))    q <= din;
    end
    assign slot_v[i] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout  = slot_v[rd_ptr];
  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

endmodule

// File: rtl/ecx_regs.sv
module ecx_regs
  import ecx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [2:0] mode,
  output logic [2:0] ctrl_mid,
  output logic [7:0] cfgb,
  output logic [7:0] plain,
  output logic       mode_chg,
  output logic       ftest,
  output logic       cfgmode
);

  logic wr_ctrl, wr_cfgb, wr_plain;

  assign ftest    = (mode == MD_FTEST);
  assign cfgmode  = (mode == MD_CONFIG);
  assign wr_ctrl  = wr_en && (addr == ADR_CTRL);
  assign wr_cfgb  = wr_en && (addr == ADR_CFGB);
  assign wr_plain = wr_en && (addr == ADR_DATA) && !ftest;
  assign mode_chg = wr_ctrl && (wdata[7:5] != mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= MD_COMPAT;
      ctrl_mid <= '0;
      cfgb     <= '0;
      plain    <= '0;
    end else begin
      if (wr_ctrl) begin
        mode     <= wdata[7:5];
        ctrl_mid <= wdata[4:2];
      end
      if (wr_cfgb)  cfgb  <= wdata;
      if (wr_plain) plain <= wdata;
    end
  end

endmodule

// File: rtl/ecx_rdport.sv
module ecx_rdport
  import ecx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_go,
  input  logic [1:0] addr,
  input  logic       ftest,
  input  logic       cfgmode,
  input  logic [7:0] ctrl_val,
  input  logic [7:0] cfga,
  input  logic [7:0] cfgb,
  input  logic [7:0] plain,
  input  logic [7:0] fifo_dout,
  input  logic       fifo_empty,
  output logic [7:0] rdata
);

  logic [7:0] hold_q;
  logic [7:0] sel;
  logic       take_fifo;

  assign take_fifo = rd_go && (addr == ADR_DATA) && ftest && !fifo_empty;

  always_comb begin
    case (addr)
      ADR_DATA: begin
        if (ftest)        sel = fifo_empty ? hold_q : fifo_dout;
        else if (cfgmode) sel = cfga;
        else              sel = plain;
      end
      ADR_CFGB: sel = cfgb;
      ADR_CTRL: sel = ctrl_val;
      default:  sel = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      hold_q <= '0;
    end else begin
      if (rd_go)     rdata  <= sel;
      if (take_fifo) hold_q <= fifo_dout;
    end
  end

endmodule

// File: rtl/ecx_bank.sv
module ecx_bank
  import ecx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 2,
  parameter int unsigned FIFO_BITS  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [2:0] mode_o
);

  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [7:0]  CFGA  = {1'b0, width_code(FIFO_BITS), 4'b0000};

  logic [2:0]       ctrl_mid;
  logic [7:0]       cfgb, plain, fifo_dout, ctrl_val;
  logic             mode_chg, ftest, cfgmode;
  logic             fifo_full, fifo_empty;
  logic [CNT_W-1:0] fifo_cnt;
  logic [1:0]       flags;

  // named events for the checker
  logic rd_go, push_evt, pop_evt, ovf_drop, unf_drop, hit_data;

  assign rd_go    = rd_en && !wr_en;
  assign hit_data = (addr == ADR_DATA) && ftest;
  assign push_evt = wr_en && hit_data && !fifo_full;
  assign ovf_drop = wr_en && hit_data && fifo_full;
  assign pop_evt  = rd_go && hit_data && !fifo_empty;
  assign unf_drop = rd_go && hit_data && fifo_empty;

  ecx_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .mode     (mode_o),
    .ctrl_mid (ctrl_mid),
    .cfgb     (cfgb),
    .plain    (plain),
    .mode_chg (mode_chg),
    .ftest    (ftest),
    .cfgmode  (cfgmode)
  );

  ecx_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_evt),
    .pop   (pop_evt),
    .clear (mode_chg),
    .din   (wdata),
    .dout  (fifo_dout),
    .count (fifo_cnt),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  assign flags    = status_of(int'(fifo_cnt), FIFO_DEPTH);
  assign ctrl_val = {mode_o, ctrl_mid, flags};

  ecx_rdport u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_go      (rd_go),
    .addr       (addr),
    .ftest      (ftest),
    .cfgmode    (cfgmode),
    .ctrl_val   (ctrl_val),
    .cfga       (CFGA),
    .cfgb       (cfgb),
    .plain      (plain),
    .fifo_dout  (fifo_dout),
    .fifo_empty (fifo_empty),
    .rdata      (rdata)
  );

endmodule

// File: rtl/ecx_bank_chk.sv
module ecx_bank_chk #(
  parameter int unsigned CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [1:0]       addr,
  input logic [7:0]       wdata,
  input logic [7:0]       rdata,
  input logic [2:0]       mode_o,
  input logic             push_evt,
  input logic             pop_evt,
  input logic             ovf_drop,
  input logic             unf_drop,
  input logic             mode_chg,
  input logic             fifo_empty,
  input logic [1:0]       flags,
  input logic [CNT_W-1:0] fifo_cnt
);

  AST_MODE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2) |=> (mode_o == $past(wdata[7:5]))); // R3

  AST_FLAG_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    flags != 2'b11); // R4

  AST_POP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_evt && !push_evt) |=> (fifo_cnt == $past(fifo_cnt) - 1'b1)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_drop |=> $stable(fifo_cnt)); // R6

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    unf_drop |=> (fifo_empty && $stable(fifo_cnt))); // R7

  AST_CLEAR_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> fifo_empty); // R8

  AST_PUSH_ONLY_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt |-> (mode_o == 3'b110)); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !wr_en) |=> $stable(rdata)); // R13

endmodule

bind ecx_bank ecx_bank_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .wdata      (wdata),
  .rdata      (rdata),
  .mode_o     (mode_o),
  .push_evt   (push_evt),
  .pop_evt    (pop_evt),
  .ovf_drop   (ovf_drop),
  .unf_drop   (unf_drop),
  .mode_chg   (mode_chg),
  .fifo_empty (fifo_empty),
  .flags      (flags),
  .fifo_cnt   (fifo_cnt)
);

// File: tb/ecx_bank_tb_top.sv
module ecx_bank_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [2:0] mode_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] last_exp = 8'h00;

  always #5 clk = ~clk;

  ecx_bank dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .mode_o (mode_o)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: compares each completed read against the scoreboard
  always begin
    @(posedge clk);
    if (rst_n && rd_en && !wr_en) begin
      #1;
      if (exp_q.size() == 0) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R13: unexpected read, actual %02h expected none", rdata);
      end else begin
        check(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    last_exp = exp;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rdata, 8'h00, "R1 rdata");
    check({5'b0, mode_o}, 8'h00, "R1 mode");
    rd(2'd2, 8'h01, "R1 ctrl");
    rd(2'd1, 8'h00, "R1 cfgb");
    rd(2'd0, 8'h00, "R1 plain");
    // R9 R10 R12 plain registers
    wr(2'd0, 8'h5A);
    rd(2'd0, 8'h5A, "R9 plain");
    wr(2'd1, 8'hC3);
    rd(2'd1, 8'hC3, "R10 cfgb");
    wr(2'd3, 8'hAB);
    rd(2'd3, 8'hFF, "R12 hole");
    rd(2'd1, 8'hC3, "R12 cfgb kept");
    // R2 R3 R11 configuration mode
    wr(2'd2, 8'hFF);
    rd(2'd2, 8'hFD, "R2 ctrl");
    @(negedge clk);
    check({5'b0, mode_o}, 8'h07, "R3 mode cfg");
    rd(2'd0, 8'h10, "R11 capability");
    wr(2'd0, 8'h33);
    // R4 R5 R6 R7 FIFO test
    wr(2'd2, 8'hC0);
    @(negedge clk);
    check({5'b0, mode_o}, 8'h06, "R3 mode test");
    rd(2'd2, 8'hC1, "R4 empty");
    wr(2'd0, 8'h11);
    rd(2'd2, 8'hC0, "R4 part");
    wr(2'd0, 8'h22);
    rd(2'd2, 8'hC2, "R4 full");
    wr(2'd0, 8'h99);
    rd(2'd2, 8'hC2, "R6 still full");
    rd(2'd0, 8'h11, "R5 pop1");
    rd(2'd2, 8'hC0, "R5 part");
    wr(2'd0, 8'h44);
    rd(2'd2, 8'hC2, "R5 wrap full");
    rd(2'd0, 8'h22, "R6 pop2");
    rd(2'd0, 8'h44, "R5 pop wrapped");
    rd(2'd2, 8'hC1, "R5 empty");
    rd(2'd0, 8'h44, "R7 empty pop");
    rd(2'd2, 8'hC1, "R7 still empty");
    // R8 same-mode rewrite keeps data, change clears
    wr(2'd0, 8'h55);
    wr(2'd2, 8'hDC);
    rd(2'd2, 8'hDC, "R8 same mode kept");
    rd(2'd0, 8'h55, "R8 pop kept");
    wr(2'd0, 8'h66);
    wr(2'd2, 8'h00);
    wr(2'd2, 8'hC0);
    rd(2'd2, 8'hC1, "R8 cleared");
    rd(2'd0, 8'h55, "R8 R7 hold after clear");
    // R9 FIFO untouched outside test mode
    wr(2'd2, 8'h00);
    rd(2'd0, 8'h33, "R9 cfg-mode write");
    wr(2'd0, 8'h77);
    rd(2'd0, 8'h77, "R9 compat plain");
    wr(2'd2, 8'hC0);
    rd(2'd2, 8'hC1, "R9 fifo untouched");
    // R13 simultaneous write and read
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; addr = 2'd1; wdata = 8'h0F;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check(rdata, last_exp, "R13 read dropped");
    rd(2'd1, 8'h0F, "R13 write done");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R13: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule